// File: doc/BRIEF.md
# Two-Wire Bus Condition Detector

This block watches the clock and data lines of a two-wire serial bus using a much faster system clock. Each line is first brought into the system clock domain by a short flop chain, then passed through a glitch filter that only accepts a new level once it has held for a set number of system-clock cycles. From the two filtered levels the block produces one-cycle pulses for bus start, bus stop, clock rising edge and clock falling edge. It also keeps a flag that shows whether the bus is idle.

The block also contains a helper for a slave that drives the data line. The slave states which level it wants through a drive request. The block holds the actual drive enable steady while the bus clock is high and for a programmable number of cycles after each falling clock edge. Only then does the new request reach the pin. This way a slave's own data change can never look like a start or stop to other devices.

Filter width and hold delay are parameters in system-clock cycles. Byte assembly and protocol decoding belong to the logic that consumes these pulses.

Top module: `twb_cond_det`

## Requirements
- R1: While reset is active and in the first cycle after it, the pulses start_o, stop_o, scl_rise_o and scl_fall_o are 0, bus_idle_o is 0 and sda_oe_o is 0; both lines are assumed high (pulled up) at reset.
- R2: A falling filtered data level while the filtered clock is high in both the current and previous cycle produces a start_o pulse exactly one cycle long.
- R3: A rising filtered data level while the filtered clock is high in both the current and previous cycle produces a stop_o pulse exactly one cycle long.
- R4: Each filtered clock transition produces exactly one one-cycle pulse, scl_rise_o for low-to-high and scl_fall_o for high-to-low. A data change while the clock is low produces neither start_o nor stop_o.
- R5: A level change on either line that lasts fewer than FILT_CYC system-clock cycles produces no event. A change held for FILT_CYC cycles or more is accepted.
- R6: bus_idle_o is 1 in the cycle of every stop_o pulse and stays 1 until a start_o pulse, in whose cycle it is 0.
- R7: An event pulse is visible in the (SYNC_STAGES + FILT_CYC + 1)-th rising clock edge after the input change, counting the first edge that samples the new level as edge 1.
- R8: After an scl_fall_o pulse, sda_oe_o keeps its value for HOLD_CYC + 1 further cycles. It first takes the requested level (sda_drive_i, 1 = pull data low) in the (HOLD_CYC + 2)-th cycle after the pulse cycle.
- R9: Changes of sda_drive_i while the filtered clock is high have no effect on sda_oe_o until the next falling clock edge and its hold delay.
- R10: While the filtered clock is low and the hold delay has expired, sda_oe_o follows sda_drive_i one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| sda_drive_i | input | 1 | Slave's requested data drive, 1 = pull low |
| start_o | output | 1 | One-cycle start pulse |
| stop_o | output | 1 | One-cycle stop pulse |
| scl_rise_o | output | 1 | One-cycle pulse on filtered clock rise |
| scl_fall_o | output | 1 | One-cycle pulse on filtered clock fall |
| bus_idle_o | output | 1 | High between a stop and the next start |
| sda_oe_o | output | 1 | Delayed data drive enable, 1 = pull low |

## Verification
The hardest cases to reach from the ports are those at the exact boundary of the glitch filter. A pulse one cycle shorter than the filter width must vanish, while a pulse of exactly the filter width on the data line, with the clock high, must produce a start followed by a stop. The stimulus starts each pulse just after a falling system-clock edge and holds it for a counted number of whole periods, so the synchroniser sees exactly that many differing samples. The hold delay is measured by counting cycles from the observed scl_fall_o pulse to the first change of sda_oe_o. This is done for both drive polarities, after drive requests were changed while the clock was high.

// File: rtl/twb_pkg.sv
package twb_pkg;
  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } twb_evt_t;

  localparam int unsigned LINE_SCL = 0;
  localparam int unsigned LINE_SDA = 1;
  localparam int unsigned N_LINES  = 2;
endpackage

// File: rtl/twb_sync.sv
module twb_sync #(
  parameter int unsigned STAGES    = 2,
  parameter bit          RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= RESET_VAL;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RESET_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/twb_glitch_filter.sv
module twb_glitch_filter #(
  parameter int unsigned WIDTH_CYC = 3,
  parameter bit          RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (WIDTH_CYC <= 1) begin : g_bypass
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_o <= RESET_VAL;
        else         q_o <= d_i;
      end
    end else begin : g_count
      localparam int unsigned CW = $clog2(WIDTH_CYC + 1);
      localparam logic [CW-1:0] LAST = CW'(WIDTH_CYC - 1);
      logic [CW-1:0] cnt_q;

      // new level accepted only after WIDTH_CYC consecutive differing samples
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          q_o   <= RESET_VAL;
          cnt_q <= '0;
        end else if (d_i == q_o) begin
          cnt_q <= '0;
        end else if (cnt_q == LAST) begin
          q_o   <= d_i;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/twb_event_det.sv
module twb_event_det
  import twb_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     scl_f_i,
  input  logic     sda_f_i,
  output twb_evt_t evt_o,
  output logic     scl_hi_o,
  output logic     bus_idle_o
);
  logic scl_q, sda_q;
  twb_evt_t evt_d;

  always_comb begin
    evt_d.start = scl_q & scl_f_i &  sda_q & ~sda_f_i;
    evt_d.stop  = scl_q & scl_f_i & ~sda_q &  sda_f_i;
    evt_d.rise  = ~scl_q &  scl_f_i;
    evt_d.fall  =  scl_q & ~scl_f_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      evt_o      <= '0;
      bus_idle_o <= 1'b0;
    end else begin
      scl_q <= scl_f_i;
      sda_q <= sda_f_i;
      evt_o <= evt_d;
      if (evt_d.start)     bus_idle_o <= 1'b0;
      else if (evt_d.stop) bus_idle_o <= 1'b1;
    end
  end

  assign scl_hi_o = scl_q;
endmodule

// File: rtl/twb_hold_delay.sv
module twb_hold_delay #(
  parameter int unsigned HOLD_CYC = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_hi_i,
  input  logic fall_i,
  input  logic drive_i,
  output logic oe_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 2);
  localparam logic [CW-1:0] LOAD = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;
  logic          open_win;

  // scl_hi_i lags the filtered level by one cycle, covering the gap before fall_i
  assign open_win = !scl_hi_i && !fall_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      oe_o  <= 1'b0;
    end else begin
      if (fall_i)              cnt_q <= LOAD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
      if (open_win)            oe_o  <= drive_i;
    end
  end
endmodule

// File: rtl/twb_cond_det.sv
module twb_cond_det
  import twb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYC    = 3,
  parameter int unsigned HOLD_CYC    = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic sda_drive_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic bus_idle_o,
  output logic sda_oe_o
);
  logic [N_LINES-1:0] raw, synced, filt;
  twb_evt_t evt;
  logic     scl_hi;

  assign raw[LINE_SCL] = scl_i;
  assign raw[LINE_SDA] = sda_i;

  generate
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
      twb_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (raw[i]),
        .q_o   (synced[i])
      );
      twb_glitch_filter #(.WIDTH_CYC(FILT_CYC), .RESET_VAL(1'b1)) u_filt (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (synced[i]),
        .q_o   (filt[i])
      );
    end
  endgenerate

  twb_event_det u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_f_i   (filt[LINE_SCL]),
    .sda_f_i   (filt[LINE_SDA]),
    .evt_o     (evt),
    .scl_hi_o  (scl_hi),
    .bus_idle_o(bus_idle_o)
  );

  twb_hold_delay #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_hi_i(scl_hi),
    .fall_i  (evt.fall),
    .drive_i (sda_drive_i),
    .oe_o    (sda_oe_o)
  );

  assign start_o    = evt.start;
  assign stop_o     = evt.stop;
  assign scl_rise_o = evt.rise;
  assign scl_fall_o = evt.fall;
endmodule

// File: rtl/twb_cond_det_chk.sv
module twb_cond_det_chk #(
  parameter int unsigned HOLD_CYC = 15
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_o,
  input logic stop_o,
  input logic scl_rise_o,
  input logic scl_fall_o,
  input logic bus_idle_o,
  input logic sda_oe_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 4) + 1;
  localparam logic [CW-1:0] SAT = '1;
  logic [CW-1:0] since_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_fall <= SAT;
    else if (scl_fall_o)      since_fall <= '0;
    else if (since_fall != SAT) since_fall <= since_fall + 1'b1;
  end

  a_r2_start_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  a_r3_stop_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !stop_o);
  a_r2_start_not_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o));
  a_r4_rise_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_rise_o |=> !scl_rise_o);
  a_r4_fall_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_fall_o |=> !scl_fall_o);
  a_r4_edges_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(scl_rise_o && scl_fall_o));
  a_r6_idle_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> bus_idle_o);
  a_r6_idle_off_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !bus_idle_o);
  a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_o && !stop_o) |-> $stable(bus_idle_o));
  a_r8_hold_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_fall <= CW'(HOLD_CYC)) |-> $stable(sda_oe_o));
endmodule

bind twb_cond_det twb_cond_det_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_o   (start_o),
  .stop_o    (stop_o),
  .scl_rise_o(scl_rise_o),
  .scl_fall_o(scl_fall_o),
  .bus_idle_o(bus_idle_o),
  .sda_oe_o  (sda_oe_o)
);

// File: tb/sim_twb_cond_det.sv
`timescale 1ns/1ps
module sim_twb_cond_det;
  localparam time CLK_PERIOD = 20ns;
  localparam int SYNC = 2;
  localparam int FILT = 3;
  localparam int HOLD = 15;
  localparam int GAP  = 20;
  localparam int EV_START = 0, EV_STOP = 1, EV_RISE = 2, EV_FALL = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_i = 1'b1, sda_i = 1'b1, sda_drive_i = 1'b0;
  logic start_o, stop_o, scl_rise_o, scl_fall_o, bus_idle_o, sda_oe_o;

  int n_chk = 0, n_bad = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  twb_cond_det #(.SYNC_STAGES(SYNC), .FILT_CYC(FILT), .HOLD_CYC(HOLD)) u0 (
    .clk_i, .rst_ni, .scl_i, .sda_i, .sda_drive_i,
    .start_o, .stop_o, .scl_rise_o, .scl_fall_o, .bus_idle_o, .sda_oe_o
  );

  function automatic string ev_req(int e);
    case (e)
      EV_START: return "R2";
      EV_STOP:  return "R3";
      default:  return "R4";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  // scoreboard monitor: every observed pulse must match the head of the queue
  task automatic take(int ev);
    int exp_ev;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL %s/R5: actual event %0d expected none at %0t", ev_req(ev), ev, $time);
    end else begin
      exp_ev = exp_q.pop_front();
      if (exp_ev != ev) begin
        n_bad++;
        $display("FAIL %s: actual event %0d expected %0d at %0t", ev_req(exp_ev), ev, exp_ev, $time);
      end
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (start_o)    take(EV_START);
      if (stop_o)     take(EV_STOP);
      if (scl_rise_o) take(EV_RISE);
      if (scl_fall_o) take(EV_FALL);
    end
  end

  task automatic measure_hold(string req, logic target);
    int k = 0;
    for (int i = 0; i < 50 && !scl_fall_o; i++) @(negedge clk_i);
    while (sda_oe_o != target && k < 4*HOLD + 8) begin
      @(negedge clk_i);
      k++;
    end
    check(req, k, HOLD + 2);
  endtask

  initial begin
    int lat;
    cyc(3);
    check("R1", {start_o, stop_o, scl_rise_o, scl_fall_o, bus_idle_o, sda_oe_o}, 0);
    rst_ni = 1'b1;
    cyc(1);
    check("R1", {start_o, stop_o, scl_rise_o, scl_fall_o, bus_idle_o, sda_oe_o}, 0);
    cyc(GAP);

    // R7 latency on a start
    exp_q.push_back(EV_START);
    sda_i = 1'b0;
    lat = 0;
    for (int i = 0; i < 40 && !start_o; i++) begin
      @(negedge clk_i);
      lat++;
    end
    check("R7", lat, SYNC + FILT + 1);
    check("R6", bus_idle_o, 0);
    cyc(GAP);

    exp_q.push_back(EV_FALL); scl_i = 1'b0; cyc(GAP);
    // R4 data changes with clock low: no start/stop
    sda_i = 1'b1; cyc(GAP);
    sda_i = 1'b0; cyc(GAP);
    check("R4", exp_q.size(), 0);
    exp_q.push_back(EV_RISE); scl_i = 1'b1; cyc(GAP);
    exp_q.push_back(EV_STOP); sda_i = 1'b1; cyc(GAP);
    check("R6", bus_idle_o, 1);

    // R5 short data glitch with clock high
    sda_i = 1'b0; cyc(FILT - 1); sda_i = 1'b1; cyc(GAP);
    check("R5", bus_idle_o, 1);
    // R5 pulse of exactly FILT cycles is accepted
    exp_q.push_back(EV_START); exp_q.push_back(EV_STOP);
    sda_i = 1'b0; cyc(FILT); sda_i = 1'b1; cyc(GAP);
    check("R5", exp_q.size(), 0);
    // R5 short clock glitch
    scl_i = 1'b0; cyc(FILT - 1); scl_i = 1'b1; cyc(GAP);
    check("R5", exp_q.size(), 0);

    // hold-delay helper
    exp_q.push_back(EV_START); sda_i = 1'b0; cyc(GAP);
    sda_drive_i = 1'b1; cyc(GAP);
    check("R9", sda_oe_o, 0);
    exp_q.push_back(EV_FALL); scl_i = 1'b0;
    measure_hold("R8", 1'b1);
    cyc(2);
    sda_drive_i = 1'b0; cyc(1);
    check("R10", sda_oe_o, 0);
    sda_drive_i = 1'b1; cyc(1);
    check("R10", sda_oe_o, 1);
    exp_q.push_back(EV_RISE); scl_i = 1'b1; cyc(GAP / 2);
    sda_drive_i = 1'b0; cyc(GAP);
    check("R9", sda_oe_o, 1);
    exp_q.push_back(EV_FALL); scl_i = 1'b0;
    measure_hold("R8", 1'b0);
    cyc(GAP);
    exp_q.push_back(EV_RISE); scl_i = 1'b1; cyc(GAP);
    exp_q.push_back(EV_STOP); sda_i = 1'b1; cyc(GAP);
    check("R6", bus_idle_o, 1);
    check("R4", exp_q.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule